// File: doc/BRIEF.md
# Predicated Element Write-Back Store with Lazy Zeroing

This block is the write-back and read stage of a small register store in which a vector is a run of consecutive scalar registers. A vector operation is issued with a base register, a length and a predicate mask. Each element result then comes back through a single write-back port, carrying the whole predicate mask of its operation, its element index and a zeroing-mode bit. Elements whose predicate bit is clear are never written.

Zeroing is lazy. In zeroing mode a masked-out element only raises a per-register zero flag. While that flag is set, reads return zero even though the storage still holds the old value. The next real write to the register clears the flag.

A busy bit per register tells the next operation which registers still wait for a result. Only registers whose predicate bit is set become busy at issue. A later operation that uses masked-out registers therefore does not stall. Three combinational read ports serve the source operands.

Top module: `pred_wb_regstore`

## Requirements
- R1: A write-back with `wb_valid` high whose element predicate `wb_mask[wb_idx]` is 1 stores `wb_data` in register `wb_reg`. The value is visible on the read ports from the following cycle.
- R2: A write-back whose element predicate is 0 in non-zeroing mode (`wb_zmode`=0) leaves the register value, its zero flag and all busy bits unchanged.
- R3: A write-back whose element predicate is 0 in zeroing mode (`wb_zmode`=1) sets the register's zero flag. From the next cycle every read of that register returns 0.
- R4: A real write (R1) clears the register's zero flag, so reads return the new data.
- R5: A write-back whose `wb_mask` is all zero changes nothing, even in zeroing mode.
- R6: Register 0 always reads 0. Writes to it are ignored, and its busy bit never sets.
- R7: An issue with `iss_valid` high sets busy for register `(iss_base+i) mod 32`, for every element `i` < `iss_len` whose `iss_mask[i]` is 1. Masked-out and out-of-length registers keep their busy state.
- R8: A real write clears the busy bit of its register. A masked write-back does not touch busy.
- R9: If an issue sets busy on the same register that a real write clears in the same cycle, the register stays busy.
- R10: The three read ports are independent and may read the same or different registers in one cycle.
- R11: After reset all registers read 0, all zero flags are clear and `busy` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue of a vector operation |
| iss_base | input | 5 | First destination register of the issued operation |
| iss_len | input | 4 | Number of elements of the issued operation |
| iss_mask | input | 8 | Predicate mask of the issued operation, bit i for element i |
| wb_valid | input | 1 | Element write-back strobe |
| wb_reg | input | 5 | Register written by this element |
| wb_idx | input | 3 | Element index within its operation |
| wb_mask | input | 8 | Full predicate mask of the element's operation |
| wb_zmode | input | 1 | 1: masked elements are zeroed lazily; 0: left alone |
| wb_data | input | 32 | Element result |
| rd_addr_a | input | 5 | Read port A register |
| rd_addr_b | input | 5 | Read port B register |
| rd_addr_c | input | 5 | Read port C register |
| rd_data_a | output | 32 | Read port A data |
| rd_data_b | output | 32 | Read port B data |
| rd_data_c | output | 32 | Read port C data |
| busy | output | 32 | Per-register busy bits |

## Verification
The assertions assume one element write-back per cycle. They also assume that the element index and the register of each write-back belong to the same issued operation. Their assertions do not judge whether a write-back matches an earlier issue; they only relate issue and write-back activity to busy and zero-flag state. The stimulus drives at most one write-back and one issue per cycle. It steers issue and write-back at the same register only in the same-cycle priority case. It always drives inputs away from the sampling edge.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_ZERO  = 2'd2
  } elem_act_e;

  // Decide what one returning element does to its register.
  function automatic elem_act_e decide_action(input logic pred_bit,
                                              input logic any_pred,
                                              input logic zmode,
                                              input logic is_r0);
    if (is_r0 || !any_pred) return ACT_NONE;
    if (pred_bit)           return ACT_WRITE;
    if (zmode)              return ACT_ZERO;
    return ACT_NONE;
  endfunction

endpackage

// File: rtl/pwb_busy_track.sv
module pwb_busy_track #(
  parameter int NUM_REGS = 32,
  parameter int VLEN_MAX = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS),
  parameter int LEN_W    = $clog2(VLEN_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  input  logic [ADDR_W-1:0]   iss_base,
  input  logic [LEN_W-1:0]    iss_len,
  input  logic [VLEN_MAX-1:0] iss_mask,
  input  logic [NUM_REGS-1:0] clr_vec,
  output logic [NUM_REGS-1:0] set_vec,
  output logic [NUM_REGS-1:0] busy_q
);

  // Registers touched by an issue: only live, in-length elements; r0 never.
  function automatic logic [NUM_REGS-1:0] issue_targets(
      input logic [ADDR_W-1:0] base, input logic [LEN_W-1:0] len,
      input logic [VLEN_MAX-1:0] mask);
    logic [NUM_REGS-1:0] r;
    r = '0;
    for (int i = 0; i < VLEN_MAX; i++) begin
      if (i < int'(len) && mask[i]) r[(int'(base) + i) % NUM_REGS] = 1'b1;
    end
    r[0] = 1'b0;
    return r;
  endfunction

  assign set_vec = iss_valid ? issue_targets(iss_base, iss_len, iss_mask) : '0;

  // A new issue wins over a completing write-back on the same register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~clr_vec) | set_vec;
  end

endmodule

// File: rtl/pwb_elem_store.sv
module pwb_elem_store
  import pwb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  elem_act_e                  act,
  input  logic [ADDR_W-1:0]          wr_reg,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] data_flat,
  output logic [NUM_REGS-1:0]        zflag_q
);

  logic [DATA_W-1:0] mem_q [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic hit;
      assign hit = (wr_reg == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g]   <= '0;
          zflag_q[g] <= 1'b0;
        end else if (hit) begin
          if (act == ACT_WRITE) begin
            mem_q[g]   <= wr_data;
            zflag_q[g] <= 1'b0;
          end else if (act == ACT_ZERO) begin
            zflag_q[g] <= 1'b1;   // storage keeps its old value
          end
        end
      end
      assign data_flat[g*DATA_W +: DATA_W] = mem_q[g];
    end
  endgenerate

endmodule

// File: rtl/pwb_read_port.sv
module pwb_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*DATA_W-1:0] data_flat,
  input  logic [NUM_REGS-1:0]        zflag,
  output logic [DATA_W-1:0]          rd_data
);

  function automatic logic [DATA_W-1:0] fetch(
      input logic [ADDR_W-1:0] a, input logic [NUM_REGS*DATA_W-1:0] flat,
      input logic [NUM_REGS-1:0] zf);
    if (a == '0 || zf[a]) return '0;
    return flat[int'(a)*DATA_W +: DATA_W];
  endfunction

  assign rd_data = fetch(addr, data_flat, zflag);

endmodule

// File: rtl/pred_wb_regstore.sv
module pred_wb_regstore
  import pwb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int VLEN_MAX = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int LEN_W   = $clog2(VLEN_MAX + 1),
  localparam int IDX_W   = $clog2(VLEN_MAX),
  localparam int NRD     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  input  logic [ADDR_W-1:0]   iss_base,
  input  logic [LEN_W-1:0]    iss_len,
  input  logic [VLEN_MAX-1:0] iss_mask,
  input  logic                wb_valid,
  input  logic [ADDR_W-1:0]   wb_reg,
  input  logic [IDX_W-1:0]    wb_idx,
  input  logic [VLEN_MAX-1:0] wb_mask,
  input  logic                wb_zmode,
  input  logic [DATA_W-1:0]   wb_data,
  input  logic [ADDR_W-1:0]   rd_addr_a,
  input  logic [ADDR_W-1:0]   rd_addr_b,
  input  logic [ADDR_W-1:0]   rd_addr_c,
  output logic [DATA_W-1:0]   rd_data_a,
  output logic [DATA_W-1:0]   rd_data_b,
  output logic [DATA_W-1:0]   rd_data_c
  ,output logic [NUM_REGS-1:0] busy
);

  // Named internal events, observed by the bound checker.
  elem_act_e             act;
  logic                  wr_fire;
  logic                  zero_fire;
  logic [NUM_REGS-1:0]   clr_vec;
  logic [NUM_REGS-1:0]   set_vec;
  logic [NUM_REGS-1:0]   zflag_q;
  logic [NUM_REGS*DATA_W-1:0] data_flat;

  assign act = wb_valid ? decide_action(wb_mask[wb_idx], |wb_mask, wb_zmode,
                                        wb_reg == '0)
                        : ACT_NONE;
  assign wr_fire   = (act == ACT_WRITE);
  assign zero_fire = (act == ACT_ZERO);
  assign clr_vec   = wr_fire ? (NUM_REGS'(1) << wb_reg) : '0;

  pwb_busy_track #(.NUM_REGS(NUM_REGS), .VLEN_MAX(VLEN_MAX),
                   .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_busy (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_base(iss_base),
    .iss_len(iss_len), .iss_mask(iss_mask), .clr_vec(clr_vec),
    .set_vec(set_vec), .busy_q(busy)
  );

  pwb_elem_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst_n(rst_n), .act(act), .wr_reg(wb_reg), .wr_data(wb_data),
    .data_flat(data_flat), .zflag_q(zflag_q)
  );

  logic [ADDR_W-1:0] rd_addr [NRD];
  logic [DATA_W-1:0] rd_data [NRD];
  assign rd_addr[0] = rd_addr_a;
  assign rd_addr[1] = rd_addr_b;
  assign rd_addr[2] = rd_addr_c;

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      pwb_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .addr(rd_addr[p]), .data_flat(data_flat), .zflag(zflag_q),
        .rd_data(rd_data[p])
      );
    end
  endgenerate

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];
  assign rd_data_c = rd_data[2];

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int VLEN_MAX = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic                wb_valid,
  input logic [ADDR_W-1:0]   wb_reg,
  input logic [VLEN_MAX-1:0] wb_mask,
  input logic [ADDR_W-1:0]   rd_addr_a,
  input logic [DATA_W-1:0]   rd_data_a,
  input logic [NUM_REGS-1:0] busy,
  input logic [NUM_REGS-1:0] zflag_q,
  input logic [NUM_REGS-1:0] set_vec,
  input logic                wr_fire,
  input logic                zero_fire
);

  a_r2_masked_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wr_fire) |=> (busy == ($past(busy) | $past(set_vec))));

  a_r3_zero_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fire |=> zflag_q[$past(wb_reg)]);

  a_r3_flag_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zflag_q[rd_addr_a] |-> (rd_data_a == '0));

  a_r4_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !zflag_q[$past(wb_reg)]);

  a_r5_empty_mask_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_mask == '0) |-> (!wr_fire && !zero_fire));

  a_r6_reg0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[0] && ((rd_addr_a == '0) -> (rd_data_a == '0)));

  a_r7_issue_sets: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> (($past(set_vec) & ~busy) == '0));

  a_r8_wb_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !set_vec[wb_reg]) |=> !busy[$past(wb_reg)]);

  a_r9_issue_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && set_vec[wb_reg]) |=> busy[$past(wb_reg)]);

endmodule

bind pred_wb_regstore pwb_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .VLEN_MAX(VLEN_MAX), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .wb_valid(wb_valid),
  .wb_reg(wb_reg), .wb_mask(wb_mask), .rd_addr_a(rd_addr_a),
  .rd_data_a(rd_data_a), .busy(busy), .zflag_q(zflag_q), .set_vec(set_vec),
  .wr_fire(wr_fire), .zero_fire(zero_fire)
);

// File: tb/test_pred_wb_regstore.sv
module test_pred_wb_regstore;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [4:0]  iss_base = '0;
  logic [3:0]  iss_len = '0;
  logic [7:0]  iss_mask = '0;
  logic        wb_valid = 1'b0;
  logic [4:0]  wb_reg = '0;
  logic [2:0]  wb_idx = '0;
  logic [7:0]  wb_mask = '0;
  logic        wb_zmode = 1'b0;
  logic [31:0] wb_data = '0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, rd_addr_c = '0;
  logic [31:0] rd_data_a, rd_data_b, rd_data_c;
  logic [31:0] busy;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  pred_wb_regstore i_pred_wb_regstore (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_base(iss_base),
    .iss_len(iss_len), .iss_mask(iss_mask), .wb_valid(wb_valid),
    .wb_reg(wb_reg), .wb_idx(wb_idx), .wb_mask(wb_mask),
    .wb_zmode(wb_zmode), .wb_data(wb_data), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .rd_addr_c(rd_addr_c), .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b), .rd_data_c(rd_data_c), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [4:0]  rg;
    logic [2:0]  idx;
    logic [7:0]  mask;
    logic        zm;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Each row: one write-back, then register rg is read back on port A.
  localparam vec_t TBL [9] = '{
    '{5'd5,  3'd0, 8'h01, 1'b0, 32'hA5A5_0001, 32'hA5A5_0001, 4'd1}, // R1 live write
    '{5'd5,  3'd1, 8'h01, 1'b0, 32'h0000_1111, 32'hA5A5_0001, 4'd2}, // R2 masked, kept
    '{5'd5,  3'd1, 8'h01, 1'b1, 32'h0000_2222, 32'h0000_0000, 4'd3}, // R3 lazy zero
    '{5'd6,  3'd2, 8'h04, 1'b0, 32'h0000_0066, 32'h0000_0066, 4'd1}, // R1 second reg
    '{5'd6,  3'd3, 8'h00, 1'b1, 32'h0000_3333, 32'h0000_0066, 4'd5}, // R5 empty mask
    '{5'd5,  3'd3, 8'h08, 1'b0, 32'h0000_0055, 32'h0000_0055, 4'd4}, // R4 flag cleared
    '{5'd0,  3'd0, 8'h01, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd6}, // R6 r0 ignored
    '{5'd31, 3'd7, 8'h80, 1'b1, 32'h0000_3131, 32'h0000_3131, 4'd1}, // R1 top reg
    '{5'd31, 3'd6, 8'h80, 1'b1, 32'h0000_9999, 32'h0000_0000, 4'd3}  // R3 zero top reg
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wb(input logic [4:0] rg, input logic [2:0] idx, input logic [7:0] mask,
                       input logic zm, input logic [31:0] data);
    wb_valid = 1'b1; wb_reg = rg; wb_idx = idx; wb_mask = mask;
    wb_zmode = zm; wb_data = data;
    step();
    wb_valid = 1'b0;
  endtask

  task automatic do_issue(input logic [4:0] base, input logic [3:0] len, input logic [7:0] mask);
    iss_valid = 1'b1; iss_base = base; iss_len = len; iss_mask = mask;
    step();
    iss_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 busy", busy, 32'h0);
    rd_addr_a = 5'd1; rd_addr_b = 5'd17; rd_addr_c = 5'd31;
    #1;
    check("R11 rd a", rd_data_a, 32'h0);
    check("R11 rd b", rd_data_b, 32'h0);
    check("R11 rd c", rd_data_c, 32'h0);

    // Table walk
    for (int k = 0; k < 9; k++) begin
      do_wb(TBL[k].rg, TBL[k].idx, TBL[k].mask, TBL[k].zm, TBL[k].data);
      rd_addr_a = TBL[k].rg;
      #1;
      check($sformatf("R%0d table row %0d", TBL[k].req, k), rd_data_a, TBL[k].exp);
    end
    check("R2 busy untouched by table", busy, 32'h0);

    // R7 wrap and length limit; R6 r0 never busy
    do_issue(5'd30, 4'd3, 8'hFF);
    check("R7 wrap busy", busy, 32'hC000_0000);

    // R8 masked write-back leaves busy, then live write clears
    do_wb(5'd30, 3'd0, 8'h02, 1'b1, 32'h0000_0BAD);
    check("R8 masked keeps busy", busy, 32'hC000_0000);
    do_wb(5'd30, 3'd0, 8'h01, 1'b0, 32'h0000_0030);
    check("R8 live write clears busy", busy, 32'h8000_0000);

    // R9 same-cycle issue and write-back on r31
    iss_valid = 1'b1; iss_base = 5'd31; iss_len = 4'd1; iss_mask = 8'h01;
    do_wb(5'd31, 3'd0, 8'h01, 1'b0, 32'h0000_0077);
    iss_valid = 1'b0;
    check("R9 issue wins", busy, 32'h8000_0000);
    rd_addr_a = 5'd31; #1;
    check("R4 r31 written after zero", rd_data_a, 32'h0000_0077);

    // R7 holes in the mask
    do_issue(5'd4, 4'd3, 8'h05);
    check("R7 masked hole", busy, 32'h8000_0050);

    do_wb(5'd31, 3'd0, 8'h01, 1'b0, 32'h0000_0099);
    check("R8 clear r31", busy, 32'h0000_0050);

    // R10 three ports at once, two on the same register
    rd_addr_a = 5'd5; rd_addr_b = 5'd6; rd_addr_c = 5'd6;
    #1;
    check("R10 port a", rd_data_a, 32'h0000_0055);
    check("R10 port b", rd_data_b, 32'h0000_0066);
    check("R10 port c", rd_data_c, 32'h0000_0066);
    rd_addr_c = 5'd30; rd_addr_b = 5'd0; #1;
    check("R10 port c r30", rd_data_c, 32'h0000_0030);
    check("R6 r0 on port b", rd_data_b, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule